// File: doc/BRIEF.md
# Tagged Hint Packer

The packer sits beside a compute unit that is allowed to run ahead of its partner. Three local producers can offer a hint: the instruction cache, the cluster-level cache and the memory controller. Each one presents a valid strobe and a 54-bit payload, which is normally an address. In every cycle the packer picks at most one enabled producer. It turns the identity of that producer into a 2-bit hint type. It then registers a 104-bit record made of the producer unit's ID, the type, the unit's current program counter, the active warp ID and the selected payload.

The record is offered to a shared hint queue with a valid/ready handshake, where ready is the inverse of the queue's full flag. While the queue is full, a pending record stays frozen and no enabled producer is accepted, so gathering stops. An effectiveness monitor supplies one enable bit per type. When a producer's type is disabled, its hints are consumed at once and discarded, and they never reach the queue.

Top module: `hint_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hintValid` is 0.
- R2: A record is laid out MSB to LSB as producer ID [103:98], type [97:96], program counter [95:64], warp ID [63:54] and payload [53:0]. The ID, PC and warp fields are the values present in the cycle in which the hint was accepted.
- R3: The type codes are 0 for the instruction cache (source bit 0), 1 for the cluster cache (bit 1) and 2 for the memory controller (bit 2). The record's payload is the payload of that source.
- R4: When several enabled sources are valid together, bit 0 wins over bit 1 and bit 1 wins over bit 2. Losing enabled sources see ready 0 in that cycle.
- R5: An enabled source whose valid and ready are both high in a cycle produces a record with `hintValid` high from the next cycle.
- R6: While `hintValid` is high and `queueFull` is high, the record and `hintValid` hold unchanged, and every enabled source sees ready 0.
- R7: A valid source whose enable bit is 0 sees ready 1 in every cycle and never produces a record.
- R8: When the record is accepted (`hintValid` high, `queueFull` low) and no new hint is accepted in the same cycle, `hintValid` is 0 in the next cycle. When a new hint is accepted, the new record follows with no idle cycle.
- R9: Type code 3 never appears on a valid record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcValid | input | 3 | Hint offered: bit0 instruction cache, bit1 cluster cache, bit2 memory controller |
| srcReady | output | 3 | Hint taken (accepted or discarded), same bit order |
| icData | input | 54 | Instruction-cache hint payload |
| ccData | input | 54 | Cluster-cache hint payload |
| mcData | input | 54 | Memory-controller hint payload |
| typeEnable | input | 3 | Per-type enable from the effectiveness monitor |
| unitId | input | 6 | ID of the producing unit |
| unitPc | input | 32 | Current program counter of the producing unit |
| warpId | input | 10 | Active warp ID |
| queueFull | input | 1 | Hint queue full (ready is its inverse) |
| hintValid | output | 1 | Record valid toward the queue |
| hintRecord | output | 104 | Packed hint record |

## Verification
A wrong output-valid flag would either lose a record, which shows as valid falling while the queue is still full, or send one twice, which shows as valid still high in the cycle after an acceptance. Both are visible one cycle after the bad edge. A wrong priority or a wrong disable decision shows in the same cycle on `srcReady`. A corrupted type or a wrongly muxed payload shows in the record in the cycle after acceptance. The bench compares the readies, the valid flag and the whole record against its model on every cycle, so any such fault is caught within one cycle of appearing.

// File: rtl/hint_packer_pkg.sv
package hint_packer_pkg;
  localparam int NUM_SRC = 3;
  localparam int ID_W    = 6;
  localparam int TYPE_W  = 2;
  localparam int PC_W    = 32;
  localparam int WARP_W  = 10;
  localparam int DATA_W  = 54;
  localparam int REC_W   = ID_W + TYPE_W + PC_W + WARP_W + DATA_W;
  localparam int TYPE_LSB = PC_W + WARP_W + DATA_W;

  typedef struct packed {
    logic              load;
    logic [TYPE_W-1:0] hintType;
  } ctrl_strobe_t;
endpackage

// File: rtl/hint_packer_ctrl.sv
module hint_packer_ctrl
  import hint_packer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [NUM_SRC-1:0] typeEnable,
  input  logic               queueFull,
  output logic [NUM_SRC-1:0] srcReady,
  output logic               hintValid,
  output ctrl_strobe_t       strobe
);
  logic              validQ;
  logic              slotFree;
  logic              found;
  logic [TYPE_W-1:0] winType;
  logic [NUM_SRC-1:0] live;

  assign live     = srcValid & typeEnable;
  assign slotFree = !validQ || !queueFull;

  always_comb begin
    found   = 1'b0;
    winType = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        found   = 1'b1;
        winType = TYPE_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      srcReady[i] = !typeEnable[i] || (found && slotFree && (winType == TYPE_W'(i)));
    end
  end

  assign strobe.load     = found && slotFree;
  assign strobe.hintType = winType;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else if (slotFree) validQ <= found;
  end

  assign hintValid = validQ;
endmodule

// File: rtl/hint_packer_dpath.sv
module hint_packer_dpath
  import hint_packer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrl_strobe_t                    strobe,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  srcData,
  input  logic [ID_W-1:0]                 unitId,
  input  logic [PC_W-1:0]                 unitPc,
  input  logic [WARP_W-1:0]               warpId,
  output logic [REC_W-1:0]                hintRecord
);
  logic [DATA_W-1:0] selData;
  logic [REC_W-1:0]  recQ;

  always_comb begin
    selData = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.hintType == TYPE_W'(i)) selData = srcData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recQ <= '0;
    else if (strobe.load) recQ <= {unitId, strobe.hintType, unitPc, warpId, selData};
  end

  assign hintRecord = recQ;
endmodule

// File: rtl/hint_packer.sv
module hint_packer
  import hint_packer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcValid,
  output logic [NUM_SRC-1:0] srcReady,
  input  logic [DATA_W-1:0]  icData,
  input  logic [DATA_W-1:0]  ccData,
  input  logic [DATA_W-1:0]  mcData,
  input  logic [NUM_SRC-1:0] typeEnable,
  input  logic [ID_W-1:0]    unitId,
  input  logic [PC_W-1:0]    unitPc,
  input  logic [WARP_W-1:0]  warpId,
  input  logic               queueFull,
  output logic               hintValid,
  output logic [REC_W-1:0]   hintRecord
);
  ctrl_strobe_t strobe;
  logic [NUM_SRC-1:0][DATA_W-1:0] srcData;

  assign srcData = {mcData, ccData, icData};

  hint_packer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .typeEnable(typeEnable),
    .queueFull(queueFull), .srcReady(srcReady), .hintValid(hintValid), .strobe(strobe)
  );

  hint_packer_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcData(srcData),
    .unitId(unitId), .unitPc(unitPc), .warpId(warpId), .hintRecord(hintRecord)
  );
endmodule

// File: rtl/hint_packer_chk.sv
module hint_packer_chk
  import hint_packer_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcValid,
  input logic [NUM_SRC-1:0] srcReady,
  input logic [NUM_SRC-1:0] typeEnable,
  input logic               queueFull,
  input logic               hintValid,
  input logic [REC_W-1:0]   hintRecord
);
  logic [NUM_SRC-1:0] taken;
  assign taken = srcValid & typeEnable & srcReady;

  AST_ONE_WINNER:   assert property (@(posedge clk) disable iff (!rstN) $onehot0(taken)); // R4
  AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rstN) ((srcValid & ~typeEnable & ~srcReady) == '0)); // R7
  AST_STALL_HOLD:   assert property (@(posedge clk) disable iff (!rstN)
                      hintValid && queueFull |=> hintValid && $stable(hintRecord)); // R6
  AST_STALL_BLOCK:  assert property (@(posedge clk) disable iff (!rstN)
                      hintValid && queueFull |-> (taken == '0)); // R6
  AST_TAKE_VALID:   assert property (@(posedge clk) disable iff (!rstN) (|taken) |=> hintValid); // R5
  AST_DRAIN:        assert property (@(posedge clk) disable iff (!rstN)
                      hintValid && !queueFull && !(|taken) |=> !hintValid); // R8
  AST_NO_CODE3:     assert property (@(posedge clk) disable iff (!rstN)
                      hintValid |-> hintRecord[TYPE_LSB +: TYPE_W] != 2'd3); // R9
endmodule

bind hint_packer hint_packer_chk u_chk (
  .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
  .typeEnable(typeEnable), .queueFull(queueFull), .hintValid(hintValid),
  .hintRecord(hintRecord)
);

// File: tb/hint_packer_tb.sv
module hint_packer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] srcValid = '0, typeEnable = 3'b111;
  logic [2:0] srcReady;
  logic [53:0] icData = '0, ccData = '0, mcData = '0;
  logic [5:0] unitId = '0;
  logic [31:0] unitPc = '0;
  logic [9:0] warpId = '0;
  logic queueFull = 1'b0;
  logic hintValid;
  logic [103:0] hintRecord;

  int checks = 0, failures = 0;
  logic mValid = 1'b0;
  logic [103:0] mRec = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hint_packer u_dut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
    .icData(icData), .ccData(ccData), .mcData(mcData), .typeEnable(typeEnable),
    .unitId(unitId), .unitPc(unitPc), .warpId(warpId), .queueFull(queueFull),
    .hintValid(hintValid), .hintRecord(hintRecord)
  );

  task automatic chk(input bit ok, input string req, input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: compare, then advance using the inputs the next edge will see
  always @(negedge clk) begin
    if (!rstN) begin
      mValid = 1'b0; mRec = '0;
      chk(hintValid == 1'b0, "R1 valid in reset", {103'b0, hintValid}, 104'b0);
    end else begin
      int win;
      bit freeSlot;
      logic [2:0] expRdy;
      logic [53:0] d;
      win = -1;
      for (int i = 2; i >= 0; i--) if (srcValid[i] && typeEnable[i]) win = i;
      freeSlot = !mValid || !queueFull;
      for (int i = 0; i < 3; i++) expRdy[i] = !typeEnable[i] || (win == i && freeSlot);
      chk(srcReady == expRdy, "R4/R6/R7 srcReady", {101'b0, srcReady}, {101'b0, expRdy});
      chk(hintValid == mValid, "R5/R6/R8 hintValid", {103'b0, hintValid}, {103'b0, mValid});
      if (mValid) begin
        chk(hintRecord == mRec, "R2/R3 hintRecord", hintRecord, mRec);
        chk(hintRecord[97:96] != 2'd3, "R9 type code", {102'b0, hintRecord[97:96]}, 104'd0);
      end
      if (freeSlot) begin
        mValid = (win >= 0);
        if (win >= 0) begin
          d = (win == 0) ? icData : (win == 1) ? ccData : mcData;
          mRec = {unitId, 2'(win), unitPc, warpId, d};
        end
      end
    end
  end

  task automatic step(input logic [2:0] v, input logic [2:0] en, input logic full);
    srcValid = v; typeEnable = en; queueFull = full;
    icData = {$urandom, $urandom}; ccData = {$urandom, $urandom}; mcData = {$urandom, $urandom};
    unitId = 6'($urandom); unitPc = $urandom; warpId = 10'($urandom);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(hintValid == 1'b0, "R1 valid after reset", {103'b0, hintValid}, 104'b0);
    @(posedge clk); #1;
    // R3: each source alone, R2 layout via model
    step(3'b001, 3'b111, 0); step(3'b010, 3'b111, 0); step(3'b100, 3'b111, 0);
    step(3'b000, 3'b111, 0);
    // R4: all three together, then two
    step(3'b111, 3'b111, 0); step(3'b110, 3'b111, 0); step(3'b000, 3'b111, 0);
    // R6: stall with queue full
    step(3'b001, 3'b111, 0); step(3'b111, 3'b111, 1); step(3'b111, 3'b111, 1);
    step(3'b010, 3'b111, 0); step(3'b000, 3'b111, 0);
    // R7: disabled types dropped
    step(3'b111, 3'b000, 0); step(3'b011, 3'b110, 0); step(3'b100, 3'b011, 1);
    step(3'b000, 3'b111, 0);
    // R8: back-to-back and random mix
    for (int n = 0; n < 3000; n++)
      step(3'($urandom), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b111,
           $urandom_range(0, 2) == 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule